// File: doc/BRIEF.md
# Programmable Parallel Bus Strobe Timer

This block runs single transfers on an 8080-style parallel display bus. A register front end hands it one request at a time. The request is a command write, a parameter write or a read. The block then drives the chip-select, write-enable and read-enable strobes and a command/data select line. Every strobe edge is placed at a tick count taken from two packed timing words.

A transfer starts at tick 0. Each strobe is asserted from its programmed "on" tick up to, but not including, its "off" tick. The transfer lasts the write cycle length or the read cycle length, counted in ticks. A read is started by a dummy write to the front end, which issues the read request. The block captures the bus input at the programmed access tick and holds it for the front end to fetch. A granularity input stretches every tick to two clocks.

The timing words are checked continuously against the ordering rules. While the set is illegal, the block raises a flag and refuses new requests. Conversion from physical time to ticks and pixel packing are done elsewhere.

Top module: `pbus_strobe_timer`

## Requirements
- R1: During and after reset, with no request, `busy`, `done`, `refused` and `bus_oe` are 0. Each of `bus_cs`, `bus_we`, `bus_re` and `bus_sel` equals its inversion input, which means the strobe is deasserted. `timing_bad` is 0 during reset.
- R2: A request is accepted at a clock edge where `req_valid`=1, `busy`=0 and `timing_bad`=0. From the next cycle, `busy` is high for exactly L×D clocks. L is the write cycle length (cycle word bits [5:0]) for `req_op` 2'b00 (command), 2'b01 or 2'b11 (parameter). L is the read cycle length (bits [11:6]) for `req_op` 2'b10 (read). D is 1, or 2 when `tick_x2`=1. `done` is high for the single cycle in which `busy` first reads 0 again.
- R3: Number the clocks after acceptance n=0,1,… and let tick k = n/D. A strobe is asserted at clock n when its on-tick ≤ k < its off-tick and the transfer is still running. The on-tick and off-tick fields sit in the on/off word: CS on [3:0], CS off [9:4], WE on [13:10], WE off [19:14], RE on [23:20], RE off [29:24]. CS is used in every transfer, WE only in writes and RE only in reads.
- R4: In a read, `rd_data` takes the value of `bus_din` present in the first clock of tick k = access time (cycle word bits [27:22]). That is clock n = access×D. `rd_data` keeps that value through later write transfers.
- R5: When `tick_x2`=1, every tick lasts two clocks. All strobe edges, the capture point and the transfer length double.
- R6: `bus_sel` is asserted for every clock of a command transfer and deasserted in parameter and read transfers. The pin level is (asserted XOR `inv_sel`).
- R7: Each strobe pin equals its asserted level XOR its inversion input (`inv_cs`, `inv_we`, `inv_re`). An inversion bit of 1 gives an idle-high, active-low pin.
- R8: One clock after the timing words change, `timing_bad` is 1 when any ordering rule fails. The rules are: WE off > WE on, RE off > RE on, CS off > CS on, CS off ≥ WE off, CS off ≥ RE off, write length ≥ WE off, read length ≥ RE off, and access > RE on. Otherwise `timing_bad` is 0.
- R9: A request made while idle with `timing_bad`=1 starts no transfer: `busy` stays 0. `refused` is high for one cycle after that edge.
- R10: A request made while `busy`=1 has no effect. The running transfer keeps its length and its `bus_dout`, `done` pulses only once, and no transfer follows.
- R11: During write transfers `bus_oe`=1 and `bus_dout` holds `req_wdata` captured at acceptance. During reads `bus_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tm_onoff | input | 30 | Packed strobe on/off ticks |
| tm_cycle | input | 28 | Packed write length, read length, access tick; bits [21:12] reserved |
| tick_x2 | input | 1 | 1: each tick lasts two clocks |
| inv_cs | input | 1 | Chip-select pin inversion |
| inv_we | input | 1 | Write-enable pin inversion |
| inv_re | input | 1 | Read-enable pin inversion |
| inv_sel | input | 1 | Command/data select pin inversion |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 command, 01/11 parameter, 10 read |
| req_wdata | input | DATA_W | Write data for the request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| refused | output | 1 | One-cycle pulse: request refused, illegal timing |
| timing_bad | output | 1 | Programmed timing violates an ordering rule |
| bus_cs | output | 1 | Chip-select pin |
| bus_we | output | 1 | Write-enable pin |
| bus_re | output | 1 | Read-enable pin |
| bus_sel | output | 1 | Command/data select pin |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | DATA_W | Data bus output |
| bus_din | input | DATA_W | Data bus input |
| rd_data | output | DATA_W | Captured read data |

## Verification
Transfers are run with two legal timing sets. The first has strobes starting past tick 0. The second has edges at tick 0, a write length equal to WE off, and a CS off beyond the transfer end. Comparing the two tells apart the edge comparisons at their inclusive and exclusive boundaries, and the cut-off at transfer end. Each kind of operation runs at full and half tick rate, so a wrong tick divider or wrong operation gating shows up as a shifted strobe or wrong length. During reads the bus input changes every clock, so a capture one clock early or late is caught. Illegal sets, each breaking one ordering rule, check the flag and the refusal. Flipped inversion inputs and a request injected mid-transfer cover the pin polarity and the ignored-while-busy rule.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 6;
  localparam int CNT_W = OFF_W;

  // on/off word layout (fields packed from bit 0 upward)
  localparam int CS_ON_LSB  = 0;
  localparam int CS_OFF_LSB = CS_ON_LSB + ON_W;
  localparam int WE_ON_LSB  = CS_OFF_LSB + OFF_W;
  localparam int WE_OFF_LSB = WE_ON_LSB + ON_W;
  localparam int RE_ON_LSB  = WE_OFF_LSB + OFF_W;
  localparam int RE_OFF_LSB = RE_ON_LSB + ON_W;
  localparam int ONOFF_W    = RE_OFF_LSB + OFF_W;

  // cycle word layout
  localparam int WCYC_LSB = 0;
  localparam int RCYC_LSB = WCYC_LSB + OFF_W;
  localparam int RSVD_LSB = RCYC_LSB + OFF_W;
  localparam int ACC_LSB  = 22;
  localparam int CYC_W    = ACC_LSB + OFF_W;

  localparam int NSTROBE = 3;
  localparam int IDX_CS  = 0;
  localparam int IDX_WE  = 1;
  localparam int IDX_RE  = 2;

  typedef enum logic [1:0] {
    OP_CMD   = 2'b00,
    OP_PARAM = 2'b01,
    OP_READ  = 2'b10,
    OP_PAR2  = 2'b11
  } op_e;

  typedef struct packed {
    logic [CNT_W-1:0] cs_on;
    logic [CNT_W-1:0] cs_off;
    logic [CNT_W-1:0] we_on;
    logic [CNT_W-1:0] we_off;
    logic [CNT_W-1:0] re_on;
    logic [CNT_W-1:0] re_off;
    logic [CNT_W-1:0] we_cyc;
    logic [CNT_W-1:0] re_cyc;
    logic [CNT_W-1:0] acc;
  } tmg_t;
endpackage

// File: rtl/pbus_legal_chk.sv
module pbus_legal_chk
  import pbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  tmg_t tm,
  output logic bad_q
);
  localparam int NRULE = 8;

  logic [NRULE-1:0] ok;
  logic             bad_d;

  always_comb begin
    ok[0] = tm.we_off > tm.we_on;
    ok[1] = tm.re_off > tm.re_on;
    ok[2] = tm.cs_off > tm.cs_on;
    ok[3] = tm.cs_off >= tm.we_off;
    ok[4] = tm.cs_off >= tm.re_off;
    ok[5] = tm.we_cyc >= tm.we_off;
    ok[6] = tm.re_cyc >= tm.re_off;
    ok[7] = tm.acc > tm.re_on;
    bad_d = ~&ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_d;
  end
endmodule

// File: rtl/pbus_tick_gen.sv
module pbus_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic half_rate,
  output logic tick_en,
  output logic first_clk
);
  logic phase_q;
  logic phase_d;

  always_comb begin
    tick_en   = active && (!half_rate || phase_q);
    first_clk = !half_rate || !phase_q;
    if (start)                    phase_d = 1'b0;
    else if (active && half_rate) phase_d = ~phase_q;
    else                          phase_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/pbus_window.sv
module pbus_window #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] on_t,
  input  logic [CW-1:0] off_t,
  input  logic          inv,
  output logic          pin
);
  logic level_q;
  logic level_d;

  always_comb level_d = gate && (cnt >= on_t) && (cnt < off_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign pin = level_q ^ inv;
endmodule

// File: rtl/pbus_strobe_timer.sv
module pbus_strobe_timer
  import pbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ONOFF_W-1:0]  tm_onoff,
  input  logic [CYC_W-1:0]    tm_cycle,
  input  logic                tick_x2,
  input  logic                inv_cs,
  input  logic                inv_we,
  input  logic                inv_re,
  input  logic                inv_sel,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                busy,
  output logic                done,
  output logic                refused,
  output logic                timing_bad,
  output logic                bus_cs,
  output logic                bus_we,
  output logic                bus_re,
  output logic                bus_sel,
  output logic                bus_oe,
  output logic [DATA_W-1:0]   bus_dout,
  input  logic [DATA_W-1:0]   bus_din,
  output logic [DATA_W-1:0]   rd_data
);
  // ---- field unpack ----
  tmg_t tm;
  logic unused_rsvd_bits;

  always_comb begin
    tm.cs_on  = CNT_W'(tm_onoff[CS_ON_LSB  +: ON_W]);
    tm.cs_off = tm_onoff[CS_OFF_LSB +: OFF_W];
    tm.we_on  = CNT_W'(tm_onoff[WE_ON_LSB  +: ON_W]);
    tm.we_off = tm_onoff[WE_OFF_LSB +: OFF_W];
    tm.re_on  = CNT_W'(tm_onoff[RE_ON_LSB  +: ON_W]);
    tm.re_off = tm_onoff[RE_OFF_LSB +: OFF_W];
    tm.we_cyc = tm_cycle[WCYC_LSB +: OFF_W];
    tm.re_cyc = tm_cycle[RCYC_LSB +: OFF_W];
    tm.acc    = tm_cycle[ACC_LSB  +: OFF_W];
  end
  assign unused_rsvd_bits = ^tm_cycle[ACC_LSB-1:RSVD_LSB];

  // ---- legality ----
  logic bad_q;
  pbus_legal_chk u_legal (
    .clk   (clk),
    .rst_n (rst_n),
    .tm    (tm),
    .bad_q (bad_q)
  );

  // ---- sequencer state ----
  logic              active_q, active_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  op_e               kind_q, kind_d;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q, refused_q;
  logic [DATA_W-1:0] rd_q;
  logic              oe_q, oe_d;
  logic              sel_q, sel_d;
  logic              accept, last, rd_en;
  logic              tick_en, first_clk;
  logic [CNT_W-1:0]  len;
  logic              rd_nxt;

  pbus_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .active    (active_q),
    .half_rate (tick_x2),
    .tick_en   (tick_en),
    .first_clk (first_clk)
  );

  always_comb begin
    accept = req_valid && !active_q && !bad_q;
    len    = (kind_q == OP_READ) ? tm.re_cyc : tm.we_cyc;
    last   = tick_en && (cnt_q == (len - CNT_W'(1)));

    if (accept)    active_d = 1'b1;
    else if (last) active_d = 1'b0;
    else           active_d = active_q;

    if (accept || last) cnt_d = '0;
    else if (tick_en)   cnt_d = cnt_q + CNT_W'(1);
    else                cnt_d = cnt_q;

    kind_d = accept ? op_e'(req_op) : kind_q;
    rd_nxt = (kind_d == OP_READ);
    oe_d   = active_d && !rd_nxt;
    sel_d  = active_d && (kind_d == OP_CMD);

    rd_en  = active_q && (kind_q == OP_READ) && first_clk && (cnt_q == tm.acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      kind_q    <= OP_PARAM;
      wdata_q   <= '0;
      done_q    <= 1'b0;
      refused_q <= 1'b0;
      rd_q      <= '0;
      oe_q      <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      active_q  <= active_d;
      cnt_q     <= cnt_d;
      kind_q    <= kind_d;
      done_q    <= last;
      refused_q <= req_valid && !active_q && bad_q;
      oe_q      <= oe_d;
      sel_q     <= sel_d;
      if (accept) wdata_q <= req_wdata;
      if (rd_en)  rd_q    <= bus_din;
    end
  end

  // ---- strobe windows, decoded from next state ----
  logic [NSTROBE-1:0] s_gate, s_inv, s_pin;
  logic [CNT_W-1:0]   s_on  [NSTROBE];
  logic [CNT_W-1:0]   s_off [NSTROBE];

  always_comb begin
    s_gate[IDX_CS] = active_d;
    s_gate[IDX_WE] = active_d && !rd_nxt;
    s_gate[IDX_RE] = active_d && rd_nxt;
    s_inv[IDX_CS]  = inv_cs;
    s_inv[IDX_WE]  = inv_we;
    s_inv[IDX_RE]  = inv_re;
    s_on[IDX_CS]   = tm.cs_on;
    s_off[IDX_CS]  = tm.cs_off;
    s_on[IDX_WE]   = tm.we_on;
    s_off[IDX_WE]  = tm.we_off;
    s_on[IDX_RE]   = tm.re_on;
    s_off[IDX_RE]  = tm.re_off;
  end

  for (genvar g = 0; g < NSTROBE; g++) begin : g_win
    pbus_window #(.CW(CNT_W)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .gate  (s_gate[g]),
      .cnt   (cnt_d),
      .on_t  (s_on[g]),
      .off_t (s_off[g]),
      .inv   (s_inv[g]),
      .pin   (s_pin[g])
    );
  end

  assign busy       = active_q;
  assign done       = done_q;
  assign refused    = refused_q;
  assign timing_bad = bad_q;
  assign bus_cs     = s_pin[IDX_CS];
  assign bus_we     = s_pin[IDX_WE];
  assign bus_re     = s_pin[IDX_RE];
  assign bus_sel    = sel_q ^ inv_sel;
  assign bus_oe     = oe_q;
  assign bus_dout   = wdata_q;
  assign rd_data    = rd_q;
endmodule

// File: rtl/pbus_strobe_timer_chk.sv
module pbus_strobe_timer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              refused,
  input logic              timing_bad,
  input logic              bus_cs,
  input logic              bus_we,
  input logic              bus_re,
  input logic              bus_sel,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_dout,
  input logic              inv_cs,
  input logic              inv_we,
  input logic              inv_re,
  input logic              inv_sel
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_cs == inv_cs && bus_we == inv_we && bus_re == inv_re &&
               bus_sel == inv_sel && !bus_oe));

  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r3_no_we_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_oe) |-> (bus_we == inv_we));

  a_r3_no_re_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_re == inv_re));

  a_r9_bad_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_bad && !busy) |=> !busy);

  a_r9_refused_idle: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> !busy);

  a_r10_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_dout));
endmodule

bind pbus_strobe_timer pbus_strobe_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .refused    (refused),
  .timing_bad (timing_bad),
  .bus_cs     (bus_cs),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_sel    (bus_sel),
  .bus_oe     (bus_oe),
  .bus_dout   (bus_dout),
  .inv_cs     (inv_cs),
  .inv_we     (inv_we),
  .inv_re     (inv_re),
  .inv_sel    (inv_sel)
);

// File: tb/pbus_strobe_timer_test.sv
`timescale 1ns/1ps
module pbus_strobe_timer_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [29:0] tm_onoff;
  logic [27:0] tm_cycle;
  logic tick_x2, inv_cs, inv_we, inv_re, inv_sel;
  logic req_valid;
  logic [1:0] req_op;
  logic [DW-1:0] req_wdata, bus_din;
  logic busy, done, refused, timing_bad;
  logic bus_cs, bus_we, bus_re, bus_sel, bus_oe;
  logic [DW-1:0] bus_dout, rd_data;

  int cs_on, cs_off, we_on, we_off, re_on, re_off, we_cyc, re_cyc, acc;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  always_comb begin
    tm_onoff = {6'(re_off), 4'(re_on), 6'(we_off), 4'(we_on), 6'(cs_off), 4'(cs_on)};
    tm_cycle = {6'(acc), 10'h2A5, 6'(re_cyc), 6'(we_cyc)};
  end

  pbus_strobe_timer #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .tm_onoff(tm_onoff), .tm_cycle(tm_cycle),
    .tick_x2(tick_x2), .inv_cs(inv_cs), .inv_we(inv_we), .inv_re(inv_re),
    .inv_sel(inv_sel), .req_valid(req_valid), .req_op(req_op),
    .req_wdata(req_wdata), .busy(busy), .done(done), .refused(refused),
    .timing_bad(timing_bad), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_re(bus_re), .bus_sel(bus_sel), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .bus_din(bus_din), .rd_data(rd_data)
  );

  // recorded per-clock observations, index n = clocks after acceptance
  logic rc [0:255];
  logic rw [0:255];
  logic rr [0:255];
  logic rb [0:255];
  logic ro [0:255];
  logic rs [0:255];
  logic [DW-1:0] rdo [0:255];
  int nlen;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_bad();
    return (we_off > we_on && re_off > re_on && cs_off > cs_on &&
            cs_off >= we_off && cs_off >= re_off && we_cyc >= we_off &&
            re_cyc >= re_off && acc > re_on) ? 0 : 1;
  endfunction

  task automatic cfg_a();
    cs_on = 1; cs_off = 9; we_on = 2; we_off = 6; re_on = 3; re_off = 8;
    we_cyc = 10; re_cyc = 12; acc = 5;
  endtask

  task automatic cfg_b();
    cs_on = 0; cs_off = 12; we_on = 0; we_off = 7; re_on = 0; re_off = 4;
    we_cyc = 7; re_cyc = 4; acc = 1;
  endtask

  task automatic do_cycle(input logic [1:0] op, input logic [DW-1:0] wd,
                          input int inject_at);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = 8'h5A;
    nlen = -1;
    for (int n = 0; n < 256; n++) begin
      rc[n] = bus_cs ^ inv_cs;  rw[n] = bus_we ^ inv_we;
      rr[n] = bus_re ^ inv_re;  rb[n] = busy;
      ro[n] = bus_oe;           rs[n] = bus_sel ^ inv_sel;
      rdo[n] = bus_dout;
      bus_din = 8'hA0 + n[7:0];
      if (n == inject_at) begin
        req_valid = 1'b1; req_op = 2'b10; req_wdata = 8'h99;
      end else req_valid = 1'b0;
      if (done) begin nlen = n; break; end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic check_cycle(input logic [1:0] op, input logic [DW-1:0] wd,
                             input string tag);
    int div, len, k, ecs, ewe, ere, eb, eo, es, ed;
    bit rd, cmd;
    rd  = (op == 2'b10);
    cmd = (op == 2'b00);
    div = tick_x2 ? 2 : 1;
    len = (rd ? re_cyc : we_cyc) * div;
    chk({tag, " R2 transfer length"}, nlen, len);
    ecs = 0; ewe = 0; ere = 0; eb = 0; eo = 0; es = 0; ed = 0;
    for (int n = 0; n < len && n < 256; n++) begin
      k = n / div;
      if (rc[n] !== (k >= cs_on && k < cs_off)) ecs++;
      if (rw[n] !== (!rd && k >= we_on && k < we_off)) ewe++;
      if (rr[n] !== (rd && k >= re_on && k < re_off)) ere++;
      if (rb[n] !== 1'b1) eb++;
      if (ro[n] !== !rd) eo++;
      if (rs[n] !== cmd) es++;
      if (!rd && rdo[n] !== wd) ed++;
    end
    chk({tag, " R3 CS window mismatches"}, ecs, 0);
    chk({tag, " R3 WE window mismatches"}, ewe, 0);
    chk({tag, " R3 RE window mismatches"}, ere, 0);
    chk({tag, " R2 busy mismatches"}, eb, 0);
    chk({tag, " R11 output enable mismatches"}, eo, 0);
    chk({tag, " R6 select mismatches"}, es, 0);
    chk({tag, " R11 write data mismatches"}, ed, 0);
    if (rd) chk({tag, " R4 captured data"}, int'(rd_data), 8'hA0 + acc * div);
  endtask

  task automatic t_reset();
    cfg_a();
    tick_x2 = 0; inv_cs = 1; inv_we = 1; inv_re = 1; inv_sel = 0;
    req_valid = 0; req_op = 2'b01; req_wdata = 0; bus_din = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 timing_bad in reset", timing_bad, 0);
    chk("R1 strobes idle in reset",
        {bus_cs, bus_we, bus_re, bus_sel, bus_oe}, {inv_cs, inv_we, inv_re, inv_sel, 1'b0});
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {busy, done, refused, bus_oe}, 0);
    chk("R8 legal set flag", timing_bad, 0);
  endtask

  task automatic t_writes();
    do_cycle(2'b00, 8'h3C, -1); check_cycle(2'b00, 8'h3C, "cmd write A");
    do_cycle(2'b01, 8'hC3, -1); check_cycle(2'b01, 8'hC3, "param write A");
    cfg_b(); repeat (2) @(negedge clk);
    chk("R8 boundary legal set", timing_bad, 0);
    do_cycle(2'b11, 8'h81, -1); check_cycle(2'b11, 8'h81, "param11 write B");
    do_cycle(2'b00, 8'h18, -1); check_cycle(2'b00, 8'h18, "cmd write B");
    cfg_a(); repeat (2) @(negedge clk);
  endtask

  task automatic t_reads();
    logic [DW-1:0] held;
    do_cycle(2'b10, 8'h00, -1); check_cycle(2'b10, 8'h00, "read A");
    held = rd_data;
    do_cycle(2'b01, 8'h42, -1); check_cycle(2'b01, 8'h42, "write after read");
    chk("R4 rd_data held over write", int'(rd_data), int'(held));
    cfg_b(); repeat (2) @(negedge clk);
    do_cycle(2'b10, 8'h00, -1); check_cycle(2'b10, 8'h00, "read B");
    cfg_a(); repeat (2) @(negedge clk);
  endtask

  task automatic t_slow();
    tick_x2 = 1;
    do_cycle(2'b00, 8'h77, -1); check_cycle(2'b00, 8'h77, "R5 slow cmd");
    do_cycle(2'b10, 8'h00, -1); check_cycle(2'b10, 8'h00, "R5 slow read");
    tick_x2 = 0;
    @(negedge clk);
  endtask

  task automatic t_polarity();
    inv_cs = 0; inv_we = 0; inv_re = 0; inv_sel = 1;
    @(negedge clk);
    chk("R7 idle pins follow inversion", {bus_cs, bus_we, bus_re, bus_sel}, 4'b0001);
    do_cycle(2'b00, 8'hE1, -1); check_cycle(2'b00, 8'hE1, "R7 flipped cmd");
    do_cycle(2'b10, 8'h00, -1); check_cycle(2'b10, 8'h00, "R7 flipped read");
    inv_cs = 1; inv_we = 1; inv_re = 1; inv_sel = 0;
    @(negedge clk);
  endtask

  task automatic t_illegal();
    for (int v = 0; v < 6; v++) begin
      cfg_a();
      case (v)
        0: we_off = we_on;
        1: re_off = 2;
        2: cs_off = 7;
        3: we_cyc = 5;
        4: re_cyc = 7;
        default: acc = re_on;
      endcase
      repeat (2) @(negedge clk);
      chk($sformatf("R8 illegal set %0d flag", v), timing_bad, exp_bad());
      req_valid = 1; req_op = 2'b01; req_wdata = 8'h66;
      @(negedge clk);
      req_valid = 0;
      chk($sformatf("R9 refused pulse set %0d", v), refused, 1);
      chk($sformatf("R9 no start set %0d", v), busy, 0);
      @(negedge clk);
      chk($sformatf("R9 refused one cycle set %0d", v), {refused, busy}, 0);
    end
    cfg_a(); repeat (2) @(negedge clk);
    chk("R8 flag clears on legal set", timing_bad, 0);
  endtask

  task automatic t_busy_ignore();
    do_cycle(2'b01, 8'h11, 2); check_cycle(2'b01, 8'h11, "R10 inject during write");
    repeat (3) begin
      @(negedge clk);
      chk("R10 nothing after done", {busy, done}, 0);
    end
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_writes();
    t_reads();
    t_slow();
    t_polarity();
    t_illegal();
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule